// File: doc/BRIEF.md
# Peripheral Reset and Clock-Stop Register Bank

This block keeps the reset and clock-stop state for up to 64 peripherals in a system control unit. It holds two 64-bit vectors, one of reset bits and one of clock-stop bits. Each vector is split into 32-bit words. Software changes a word only through set and clear accesses. A write to the word's base offset turns on every bit that is one in the data. A write to the offset four bytes above turns off every bit that is one in the data. In both cases all other bits stay as they were. This lets several drivers each control their own peripheral bits without a read-modify-write sequence.

The stored bits drive the per-peripheral outputs directly. A reset output is high while its peripheral is held in reset. A clock-enable output is high while that peripheral's clock runs. For clock bits, a stored one normally means stopped. One line, index 14 by default, has the opposite sense: a stored one means its clock runs. Reads are combinational and return the stored word at either the base or the alias offset. Some peripherals have no reset line, and their clock enable depends only on the clock-stop bit.

Top module: `scu_rst_clk_bank`

## Requirements
- R1: After reset, both reset words read 0xFFFFFFFF. Clock word 0 reads 0xFFFFBFFF (only bit 14 clear) and clock word 1 reads 0xFFFFFFFF. Every `periph_rst` bit is 1 and every `clk_en` bit is 0.
- R2: A write to a base offset sets each stored bit whose write-data bit is 1 and leaves the others unchanged. The base offsets are 0x040 for reset word 0, 0x050 for reset word 1, 0x080 for clock word 0 and 0x090 for clock word 1. The new value is visible on `rdata` and on the outputs from the cycle after the write edge.
- R3: A write to base + 0x4 (0x044, 0x054, 0x084 or 0x094) clears each stored bit whose write-data bit is 1 and leaves the others unchanged.
- R4: Line i (0 to 63) is bit i mod 32 of word i / 32. `periph_rst[i]` equals reset bit i, where 1 means held in reset.
- R5: For every line except 14, `clk_en[i]` is the inverse of clock-stop bit i. For line 14, `clk_en[14]` equals its stored bit.
- R6: A read at a base offset or at its alias offset returns the stored 32-bit word on `rdata` in the same cycle.
- R7: A write to any other offset changes no stored bit and no output. A read of any other offset returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Single-cycle write strobe |
| addr | input | 12 | Byte offset of the access |
| wdata | input | 32 | Write data; ones mark the bits to set or clear |
| rdata | output | 32 | Combinational read data |
| periph_rst | output | 64 | Per-peripheral reset, 1 = held in reset |
| clk_en | output | 64 | Per-peripheral clock enable, 1 = running |

## Verification
The hardest case to reach from the ports is line 14, whose enable sense is reversed. It only shows up once the bit's stored state differs from its reset value. The stimulus clears the whole of clock word 0, so every other enable turns on while line 14 stays off. It then sets only bit 14 and checks that this one enable comes on and no other enable changes. The stimulus also writes to unmapped offsets that sit next to mapped ones: a misaligned offset just above a base, and the gap between the word-0 and word-1 pairs. It then confirms that the stored words and both output vectors still hold their earlier values.

// File: rtl/scu_rst_clk_bank.sv
module scu_rst_clk_bank #(
  parameter int ADDR_W   = 12,
  parameter int NWORDS   = 2,
  parameter int RST_BASE = 'h040,
  parameter int CLK_BASE = 'h080,
  parameter int STRIDE   = 'h010,
  parameter int INV_LINE = 14
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [31:0]            wdata,
  output logic [31:0]            rdata,
  output logic [NWORDS*32-1:0]   periph_rst,
  output logic [NWORDS*32-1:0]   clk_en
);
  localparam int LINES = NWORDS * 32;
  localparam logic [LINES-1:0] POL = {{(LINES-1){1'b0}}, 1'b1} << INV_LINE;

  logic [LINES-1:0] stop_vec;
  logic [31:0] rd_word [2*NWORDS];

  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    localparam int RB = RST_BASE + w * STRIDE;
    localparam int CB = CLK_BASE + w * STRIDE;
    logic [31:0] r_q, s_q;
    logic r_set, r_clr, s_set, s_clr;

    assign r_set = wr_en && (addr == ADDR_W'(RB));
    assign r_clr = wr_en && (addr == ADDR_W'(RB + 4));
    assign s_set = wr_en && (addr == ADDR_W'(CB));
    assign s_clr = wr_en && (addr == ADDR_W'(CB + 4));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        r_q <= '1;
        s_q <= ~POL[w*32 +: 32];
      end else begin
        if (r_set)      r_q <= r_q | wdata;
        else if (r_clr) r_q <= r_q & ~wdata;
        if (s_set)      s_q <= s_q | wdata;
        else if (s_clr) s_q <= s_q & ~wdata;
      end
    end

    assign periph_rst[w*32 +: 32] = r_q;
    assign stop_vec[w*32 +: 32]   = s_q;
    assign rd_word[2*w]   = (addr == ADDR_W'(RB) || addr == ADDR_W'(RB + 4)) ? r_q : 32'h0;
    assign rd_word[2*w+1] = (addr == ADDR_W'(CB) || addr == ADDR_W'(CB + 4)) ? s_q : 32'h0;
  end

  assign clk_en = ~(stop_vec ^ POL);

  always_comb begin
    rdata = 32'h0;
    for (int i = 0; i < 2*NWORDS; i++) rdata = rdata | rd_word[i];
  end
endmodule

module scu_rst_clk_bank_chk #(
  parameter int ADDR_W   = 12,
  parameter int NWORDS   = 2,
  parameter int RST_BASE = 'h040,
  parameter int CLK_BASE = 'h080,
  parameter int STRIDE   = 'h010,
  parameter int INV_LINE = 14
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wr_en,
  input logic [ADDR_W-1:0]    addr,
  input logic [31:0]          wdata,
  input logic [31:0]          rdata,
  input logic [NWORDS*32-1:0] periph_rst,
  input logic [NWORDS*32-1:0] clk_en
);
  localparam int INV_CB = CLK_BASE + (INV_LINE / 32) * STRIDE;

  // R2
  rst_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr == ADDR_W'(RST_BASE) |=>
      periph_rst[31:0] == ($past(periph_rst[31:0]) | $past(wdata)));

  // R3
  rst_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr == ADDR_W'(RST_BASE + 4) |=>
      periph_rst[31:0] == ($past(periph_rst[31:0]) & ~$past(wdata)));

  // R5
  run_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr == ADDR_W'(INV_CB) && wdata[INV_LINE % 32] |=> clk_en[INV_LINE]);

  // R5
  stop_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr == ADDR_W'(CLK_BASE) && wdata[0] && INV_LINE != 0 |=> !clk_en[0]);

  // R7
  ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr[1:0] != 2'b00 |=> $stable(periph_rst) && $stable(clk_en));

  // R6
  always_comb begin
    if (rst_n && addr == ADDR_W'(RST_BASE + 4))
      alias_rd_chk: assert (rdata == periph_rst[31:0]);
  end
endmodule

bind scu_rst_clk_bank scu_rst_clk_bank_chk #(
  .ADDR_W(ADDR_W), .NWORDS(NWORDS), .RST_BASE(RST_BASE),
  .CLK_BASE(CLK_BASE), .STRIDE(STRIDE), .INV_LINE(INV_LINE)
) u_chk (.*);

// File: tb/scu_rst_clk_bank_tb.sv
module scu_rst_clk_bank_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [63:0] periph_rst, clk_en;
  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  scu_rst_clk_bank u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .periph_rst(periph_rst), .clk_en(clk_en)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; addr = 12'hFFC; wdata = '0;
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
    @(negedge clk);
    addr = a;
    #5;
    chk(req, {32'h0, rdata}, {32'h0, exp});
  endtask

  task automatic t_reset;
    rd_chk("R1 rst0", 12'h040, 32'hFFFFFFFF);
    rd_chk("R1 rst1", 12'h050, 32'hFFFFFFFF);
    rd_chk("R1 clk0", 12'h080, 32'hFFFFBFFF);
    rd_chk("R1 clk1", 12'h090, 32'hFFFFFFFF);
    chk("R1 periph_rst", periph_rst, '1);
    chk("R1 clk_en", clk_en, '0);
  endtask

  task automatic t_set_clear;
    wr(12'h044, 32'h000000F0);
    rd_chk("R3 clear rst0", 12'h040, 32'hFFFFFF0F);
    wr(12'h040, 32'h00000030);
    rd_chk("R2 set rst0", 12'h040, 32'hFFFFFF3F);
    rd_chk("R6 alias rst0", 12'h044, 32'hFFFFFF3F);
    wr(12'h054, 32'hFFFF0000);
    rd_chk("R3 clear rst1", 12'h050, 32'h0000FFFF);
    wr(12'h050, 32'h00010000);
    rd_chk("R2 set rst1", 12'h050, 32'h0001FFFF);
    rd_chk("R6 alias rst1", 12'h054, 32'h0001FFFF);
    wr(12'h040, 32'h0);
    rd_chk("R2 zero data", 12'h040, 32'hFFFFFF3F);
  endtask

  task automatic t_mapping;
    #5;
    chk("R4 line7:4", {60'h0, periph_rst[7:4]}, 64'h3);
    chk("R4 line47:32", {48'h0, periph_rst[47:32]}, 64'hFFFF);
    chk("R4 line48", {63'h0, periph_rst[48]}, 64'h1);
    chk("R4 line63:49", {49'h0, periph_rst[63:49]}, 64'h0);
  endtask

  task automatic t_polarity;
    wr(12'h084, 32'hFFFFFFFF);
    #5;
    chk("R5 clk0 cleared", {32'h0, clk_en[31:0]}, 64'hFFFFBFFF);
    wr(12'h080, 32'h00004000);
    #5;
    chk("R5 line14 runs", {32'h0, clk_en[31:0]}, 64'hFFFFFFFF);
    rd_chk("R6 alias clk0", 12'h084, 32'h00004000);
    wr(12'h094, 32'h00000001);
    #5;
    chk("R5 clk1", {32'h0, clk_en[63:32]}, 64'h1);
    rd_chk("R3 clk1 word", 12'h090, 32'hFFFFFFFE);
    wr(12'h080, 32'h00000001);
    #5;
    chk("R5 stop line0", {32'h0, clk_en[31:0]}, 64'hFFFFFFFE);
  endtask

  task automatic t_unmapped;
    logic [63:0] pr, ce;
    #5;
    pr = periph_rst; ce = clk_en;
    wr(12'h048, 32'hFFFFFFFF);
    wr(12'h042, 32'hFFFFFFFF);
    wr(12'h088, 32'hFFFFFFFF);
    wr(12'h100, 32'hFFFFFFFF);
    #5;
    chk("R7 periph_rst kept", periph_rst, pr);
    chk("R7 clk_en kept", clk_en, ce);
    rd_chk("R7 rst0 kept", 12'h040, 32'hFFFFFF3F);
    rd_chk("R7 read gap", 12'h048, 32'h0);
    rd_chk("R7 read misaligned", 12'h041, 32'h0);
    rd_chk("R7 read far", 12'h300, 32'h0);
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    addr = 12'hFFC;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_set_clear();
    t_mapping();
    t_polarity();
    t_unmapped();
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule